// File: doc/BRIEF.md
# Indirect Execution Control Port

This block is a register slave that lets a host reach an engine's instruction memory, data memory and execution-context register file without mapping them into its own address space. The host sees only three words: a data word, an address word and a combined command/status word. To write a storage location the host first loads the data word, then the address word, and finally writes a command code. To read one, it loads the address word and writes the read command; the fetched value lands in the data word a couple of cycles later, and the host reads it from there.

The same command word also drives the engine's execution state. Start, stop, single-step, pipeline clear and profile-counter clear are each a command code. Reading the command/status word reports running, stopped, cleared and pipeline-clean flags. The engine datapath is a stub: a single step counts one completed instruction on the watch counter, and a profile counter counts the cycles spent running.

Top module: `exec_ctl_port`

## Requirements
- R1: After reset the status word reads 0x4080_0000 (stopped bit 30 and pipeline-clean bit 23 set, running bit 31 and cleared bit 29 clear), `running` is 0, both counters are 0 and `bus_ready` is 0.
- R2: Host offsets are 0 data, 1 address, 2 command/status. A transfer accepted at one edge raises `bus_ready` for the following cycle only, and a read returns its word in `bus_rdata` in that cycle. Offset 3 ignores writes and reads as 0. The command code is taken from bits [7:0] of a write to offset 2.
- R3: Code 0x11 writes the data word into instruction memory at the address word, and code 0x10 reads it back into the data word.
- R4: Codes 0x13 and 0x12 write and read data memory, which is separate from instruction memory: a write to one leaves the same address in the other unchanged.
- R5: Codes 0x15 and 0x14 write and read the context register file. A write to an index whose two low bits are 0 keeps only bit 31 (active), bits [28:16] (next PC) and bits [10:8] (load duration), with the other bits reading 0. Every other index keeps all 32 bits.
- R6: A data-word read accepted at the first edge after a read command returns the previous data word. A read accepted at the third edge or later returns the fetched value.
- R7: Code 0x02 sets the running flag and clears the stopped flag, one edge after the command is accepted.
- R8: Code 0x03 clears the running flag and sets the stopped flag.
- R9: Code 0x04 sets the cleared (bit 29) and pipeline-clean (bit 23) flags. A start, or a step taken while stopped, clears both.
- R10: Code 0x01 while stopped adds exactly 1 to the watch counter one edge after the command is accepted.
- R11: Code 0x01 while running leaves the watch counter unchanged.
- R12: The profile counter advances by one for each cycle the engine is running, holds while stopped, and code 0x0C sets it to 0.
- R13: Any other command code changes no flag, no counter, no memory and no context register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Host transfer request, one cycle per transfer |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Host word offset |
| bus_wdata | input | 32 | Host write data |
| bus_ready | output | 1 | Transfer completed, one cycle after acceptance |
| bus_rdata | output | 32 | Host read data, valid with `bus_ready` |
| running | output | 1 | Engine running flag |
| watch_count | output | WCW | Completed single-step instructions |
| prof_count | output | PCW | Cycles spent running since last clear |

## Verification
The assertions take for granted that the host holds `bus_valid` for one cycle per transfer. They also assume that no new command or data-word write arrives while a read is still in flight, because a fetched value and a host write to the data word would then meet at the same edge. The stimulus keeps to this by sending every transfer as a single-cycle pulse. After each read command it leaves at least two idle cycles before the next command or data-word write. The only exception is the deliberate early data-word read, which touches nothing.

// File: rtl/ecp_pkg.sv
// Package: shared command codes, host offsets, status bit positions and
// the context-register field mask used by the execution control port.
package ecp_pkg;

    // Host word offsets on the register bus.
    typedef enum logic [1:0] {
        HR_DATA = 2'd0,
        HR_ADDR = 2'd1,
        HR_CTRL = 2'd2,
        HR_NONE = 2'd3
    } host_reg_e;

    // Command codes written to the control word.
    localparam logic [7:0] OP_STEP     = 8'h01;
    localparam logic [7:0] OP_START    = 8'h02;
    localparam logic [7:0] OP_STOP     = 8'h03;
    localparam logic [7:0] OP_FLUSH    = 8'h04;
    localparam logic [7:0] OP_PROF_CLR = 8'h0C;
    localparam logic [7:0] OP_IMEM_RD  = 8'h10;
    localparam logic [7:0] OP_IMEM_WR  = 8'h11;
    localparam logic [7:0] OP_DMEM_RD  = 8'h12;
    localparam logic [7:0] OP_DMEM_WR  = 8'h13;
    localparam logic [7:0] OP_CTX_RD   = 8'h14;
    localparam logic [7:0] OP_CTX_WR   = 8'h15;

    // Which store a pending read returns from.
    typedef enum logic [1:0] {
        SRC_IMEM = 2'd0,
        SRC_DMEM = 2'd1,
        SRC_CTX  = 2'd2
    } rd_src_e;

    // Execution flags reported in the status word.
    typedef struct packed {
        logic run;
        logic halted;
        logic flushed;
        logic clean;
    } exec_flags_t;

    localparam int ST_RUN_BIT   = 31;
    localparam int ST_HALT_BIT  = 30;
    localparam int ST_FLUSH_BIT = 29;
    localparam int ST_CLEAN_BIT = 23;

    // Bits kept on a write to a level-0 context register:
    // active flag, next PC and load duration.
    localparam logic [31:0] CTX_L0_KEEP = 32'h9FFF_0700;

    // Build the 32-bit status word from the flag set.
    function automatic logic [31:0] pack_status(exec_flags_t f);
        logic [31:0] w;
        w               = '0;
        w[ST_RUN_BIT]   = f.run;
        w[ST_HALT_BIT]  = f.halted;
        w[ST_FLUSH_BIT] = f.flushed;
        w[ST_CLEAN_BIT] = f.clean;
        return w;
    endfunction

endpackage

// File: rtl/ecp_store.sv
// Module: ecp_store
// Single-port-per-direction synchronous store with registered read data.
// Assumes one write and one read port; a read returns data one edge after
// its enable. The array itself is not reset.
module ecp_store #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Write port: store the word on an enabled edge.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read port: register the addressed word when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/ecp_host_regs.sv
// Module: ecp_host_regs
// Host-facing register file: data word, address word and command strobe,
// plus a one-cycle bus response. Assumes single-cycle bus_valid pulses and
// that a returning read result never coincides with a host data-word write
// (the return wins if it does).
module ecp_host_regs #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [1:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ready,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       status_word,
    input  logic              ret_valid,
    input  logic [31:0]       ret_data,
    output logic [31:0]       data_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              cmd_stb,
    output logic [7:0]        cmd_code
);
    import ecp_pkg::*;

    logic wr_hit;
    logic rd_hit;

    // Qualify the transfer direction.
    always_comb begin
        wr_hit = bus_valid && bus_write;
        rd_hit = bus_valid && !bus_write;
    end

    // Bus response: ready one cycle after acceptance, read data alongside.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ready <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ready <= bus_valid;
            if (rd_hit) begin
                case (bus_addr)
                    HR_DATA: bus_rdata <= data_q;
                    HR_ADDR: bus_rdata <= 32'(addr_q);
                    HR_CTRL: bus_rdata <= status_word;
                    default: bus_rdata <= '0;
                endcase
            end
        end
    end

    // Data and address words, with read results landing in the data word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            addr_q <= '0;
        end else begin
            if (wr_hit && bus_addr == HR_DATA) begin
                data_q <= bus_wdata;
            end
            if (wr_hit && bus_addr == HR_ADDR) begin
                addr_q <= bus_wdata[ADDR_W-1:0];
            end
            if (ret_valid) begin
                data_q <= ret_data;
            end
        end
    end

    // Command strobe: one cycle after a control-word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_stb  <= 1'b0;
            cmd_code <= '0;
        end else begin
            cmd_stb <= wr_hit && bus_addr == HR_CTRL;
            if (wr_hit && bus_addr == HR_CTRL) begin
                cmd_code <= bus_wdata[7:0];
            end
        end
    end

endmodule

// File: rtl/ecp_sequencer.sv
// Module: ecp_sequencer
// Decodes a command strobe into store accesses, execution-flag updates and
// engine requests, and returns read results two edges after the command
// write. Assumes no new command is issued while a read is in flight.
module ecp_sequencer #(
    parameter int CTX_AW = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_stb,
    input  logic [7:0]          cmd_code,
    input  logic [1:0]          ctx_level,
    input  logic [31:0]         data_q,
    input  logic [31:0]         imem_rdata,
    input  logic [31:0]         dmem_rdata,
    input  logic [31:0]         ctx_rdata,
    output logic                imem_we,
    output logic                imem_re,
    output logic                dmem_we,
    output logic                dmem_re,
    output logic                ctx_we,
    output logic                ctx_re,
    output logic [31:0]         ctx_wdata,
    output logic                step_req,
    output logic                prof_clr,
    output ecp_pkg::exec_flags_t flags,
    output logic                ret_valid,
    output logic [31:0]         ret_data
);
    import ecp_pkg::*;

    logic    do_start;
    logic    do_stop;
    logic    do_flush;
    logic    do_step;
    logic    rd_pend;
    rd_src_e rd_src;

    // Decode the strobed command into one-cycle actions.
    always_comb begin
        imem_re  = cmd_stb && cmd_code == OP_IMEM_RD;
        imem_we  = cmd_stb && cmd_code == OP_IMEM_WR;
        dmem_re  = cmd_stb && cmd_code == OP_DMEM_RD;
        dmem_we  = cmd_stb && cmd_code == OP_DMEM_WR;
        ctx_re   = cmd_stb && cmd_code == OP_CTX_RD;
        ctx_we   = cmd_stb && cmd_code == OP_CTX_WR;
        do_start = cmd_stb && cmd_code == OP_START;
        do_stop  = cmd_stb && cmd_code == OP_STOP;
        do_flush = cmd_stb && cmd_code == OP_FLUSH;
        do_step  = cmd_stb && cmd_code == OP_STEP;
        prof_clr = cmd_stb && cmd_code == OP_PROF_CLR;
        step_req = do_step && !flags.run;
    end

    // Level-0 context registers keep only their defined fields.
    always_comb begin
        if (ctx_level == 2'b00) begin
            ctx_wdata = data_q & CTX_L0_KEEP;
        end else begin
            ctx_wdata = data_q;
        end
    end

    // Execution flags: start, stop, flush and step transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '{run: 1'b0, halted: 1'b1, flushed: 1'b0, clean: 1'b1};
        end else begin
            if (do_start) begin
                flags.run     <= 1'b1;
                flags.halted  <= 1'b0;
                flags.flushed <= 1'b0;
                flags.clean   <= 1'b0;
            end
            if (do_stop) begin
                flags.run    <= 1'b0;
                flags.halted <= 1'b1;
            end
            if (do_flush) begin
                flags.flushed <= 1'b1;
                flags.clean   <= 1'b1;
            end
            if (step_req) begin
                flags.flushed <= 1'b0;
                flags.clean   <= 1'b0;
            end
        end
    end

    // Read tracking: remember the source for the return edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            rd_src  <= SRC_IMEM;
        end else begin
            rd_pend <= imem_re || dmem_re || ctx_re;
            if (dmem_re) begin
                rd_src <= SRC_DMEM;
            end else if (ctx_re) begin
                rd_src <= SRC_CTX;
            end else if (imem_re) begin
                rd_src <= SRC_IMEM;
            end
        end
    end

    // Return path: select the store that was read.
    always_comb begin
        ret_valid = rd_pend;
        case (rd_src)
            SRC_DMEM: ret_data = dmem_rdata;
            SRC_CTX:  ret_data = ctx_rdata;
            default:  ret_data = imem_rdata;
        endcase
    end

endmodule

// File: rtl/ecp_engine_stub.sv
// Module: ecp_engine_stub
// Stand-in for the engine datapath: counts completed single steps and the
// cycles spent running. Assumes step requests arrive only while stopped.
module ecp_engine_stub #(
    parameter int WCW = 16,
    parameter int PCW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           step_req,
    input  logic           prof_clr,
    output logic [WCW-1:0] watch_count,
    output logic [PCW-1:0] prof_count
);
    // Watch counter: one per completed single step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            watch_count <= '0;
        end else if (step_req) begin
            watch_count <= watch_count + WCW'(1);
        end
    end

    // Profile counter: cycles while running, cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prof_count <= '0;
        end else if (prof_clr) begin
            prof_count <= '0;
        end else if (run) begin
            prof_count <= prof_count + PCW'(1);
        end
    end

endmodule

// File: rtl/exec_ctl_port.sv
// Module: exec_ctl_port
// Top of the indirect execution control port: host registers, command
// sequencer, instruction/data/context stores and the engine stub.
// Assumes the host sends single-cycle transfers and leaves a read command
// two cycles to complete before the next command or data-word write.
module exec_ctl_port #(
    parameter int IMEM_AW = 8,
    parameter int DMEM_AW = 8,
    parameter int CTX_AW  = 5,
    parameter int WCW     = 16,
    parameter int PCW     = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_valid,
    input  logic           bus_write,
    input  logic [1:0]     bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic           bus_ready,
    output logic [31:0]    bus_rdata,
    output logic           running,
    output logic [WCW-1:0] watch_count,
    output logic [PCW-1:0] prof_count
);
    import ecp_pkg::*;

    localparam int MEM_AW = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW;
    localparam int ADDR_W = (MEM_AW > CTX_AW) ? MEM_AW : CTX_AW;

    logic [31:0]       data_q;
    logic [ADDR_W-1:0] addr_q;
    logic              cmd_stb;
    logic [7:0]        cmd_code;
    logic              ret_valid;
    logic [31:0]       ret_data;
    logic [31:0]       status_word;
    exec_flags_t       flags;
    logic              imem_we, imem_re, dmem_we, dmem_re, ctx_we, ctx_re;
    logic [31:0]       ctx_wdata;
    logic [31:0]       imem_rdata, dmem_rdata, ctx_rdata;
    logic              step_req;
    logic              prof_clr;

    // Status word and running output from the flag set.
    always_comb begin
        status_word = pack_status(flags);
        running     = flags.run;
    end

    ecp_host_regs #(.ADDR_W(ADDR_W)) u_host (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_ready   (bus_ready),
        .bus_rdata   (bus_rdata),
        .status_word (status_word),
        .ret_valid   (ret_valid),
        .ret_data    (ret_data),
        .data_q      (data_q),
        .addr_q      (addr_q),
        .cmd_stb     (cmd_stb),
        .cmd_code    (cmd_code)
    );

    ecp_sequencer #(.CTX_AW(CTX_AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_stb    (cmd_stb),
        .cmd_code   (cmd_code),
        .ctx_level  (addr_q[1:0]),
        .data_q     (data_q),
        .imem_rdata (imem_rdata),
        .dmem_rdata (dmem_rdata),
        .ctx_rdata  (ctx_rdata),
        .imem_we    (imem_we),
        .imem_re    (imem_re),
        .dmem_we    (dmem_we),
        .dmem_re    (dmem_re),
        .ctx_we     (ctx_we),
        .ctx_re     (ctx_re),
        .ctx_wdata  (ctx_wdata),
        .step_req   (step_req),
        .prof_clr   (prof_clr),
        .flags      (flags),
        .ret_valid  (ret_valid),
        .ret_data   (ret_data)
    );

    ecp_store #(.AW(IMEM_AW), .DW(32)) u_imem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (imem_we),
        .waddr (addr_q[IMEM_AW-1:0]),
        .wdata (data_q),
        .re    (imem_re),
        .raddr (addr_q[IMEM_AW-1:0]),
        .rdata (imem_rdata)
    );

    ecp_store #(.AW(DMEM_AW), .DW(32)) u_dmem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dmem_we),
        .waddr (addr_q[DMEM_AW-1:0]),
        .wdata (data_q),
        .re    (dmem_re),
        .raddr (addr_q[DMEM_AW-1:0]),
        .rdata (dmem_rdata)
    );

    ecp_store #(.AW(CTX_AW), .DW(32)) u_ctx (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctx_we),
        .waddr (addr_q[CTX_AW-1:0]),
        .wdata (ctx_wdata),
        .re    (ctx_re),
        .raddr (addr_q[CTX_AW-1:0]),
        .rdata (ctx_rdata)
    );

    ecp_engine_stub #(.WCW(WCW), .PCW(PCW)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (flags.run),
        .step_req    (step_req),
        .prof_clr    (prof_clr),
        .watch_count (watch_count),
        .prof_count  (prof_count)
    );

endmodule

// File: rtl/ecp_checker.sv
// Module: ecp_checker
// Temporal checks on the execution control port, bound into the top.
// Assumes single-cycle host transfers.
module ecp_checker #(
    parameter int WCW = 16,
    parameter int PCW = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_valid,
    input logic           bus_ready,
    input logic           running,
    input logic [WCW-1:0] watch_count,
    input logic [PCW-1:0] prof_count,
    input logic           cmd_stb,
    input logic [7:0]     cmd_code,
    input logic           prof_clr
);
    import ecp_pkg::*;

    // R2: every accepted transfer is answered in the next cycle.
    a_r2_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> bus_ready);

    // R2: no response without a transfer.
    a_r2_no_spurious_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !bus_ready);

    // R7: start leaves the engine running.
    a_r7_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_code == OP_START) |=> running);

    // R8: stop leaves the engine halted.
    a_r8_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_code == OP_STOP) |=> !running);

    // R10: a step while stopped adds exactly one.
    a_r10_step_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_code == OP_STEP && !running)
        |=> watch_count == $past(watch_count) + WCW'(1));

    // R11: a step while running is ignored.
    a_r11_step_ignored_running: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_code == OP_STEP && running) |=> $stable(watch_count));

    // R12: the profile counter holds while stopped and not cleared.
    a_r12_prof_holds_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !prof_clr) |=> $stable(prof_count));

    // R13: the watch counter moves only on a step command.
    a_r13_watch_only_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_stb && cmd_code == OP_STEP) |=> $stable(watch_count));

endmodule

bind exec_ctl_port ecp_checker #(.WCW(WCW), .PCW(PCW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_ready   (bus_ready),
    .running     (running),
    .watch_count (watch_count),
    .prof_count  (prof_count),
    .cmd_stb     (cmd_stb),
    .cmd_code    (cmd_code),
    .prof_clr    (prof_clr)
);

// File: tb/test_exec_ctl_port.sv
// Directed bench for the execution control port: one task per scenario.
module test_exec_ctl_port;

    localparam int WCW = 16;
    localparam int PCW = 32;
    localparam logic [31:0] S_RUN   = 32'h8000_0000;
    localparam logic [31:0] S_HALT  = 32'h4000_0000;
    localparam logic [31:0] S_FLUSH = 32'h2000_0000;
    localparam logic [31:0] S_CLEAN = 32'h0080_0000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_valid = 1'b0;
    logic           bus_write = 1'b0;
    logic [1:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic           bus_ready;
    logic [31:0]    bus_rdata;
    logic           running;
    logic [WCW-1:0] watch_count;
    logic [PCW-1:0] prof_count;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    exec_ctl_port #(.WCW(WCW), .PCW(PCW)) i_exec_ctl_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_ready   (bus_ready),
        .bus_rdata   (bus_rdata),
        .running     (running),
        .watch_count (watch_count),
        .prof_count  (prof_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] d, output logic rdy);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata; rdy = bus_ready;
        bus_valid = 1'b0;
    endtask

    task automatic issue(input logic [7:0] code);
        bus_wr(2'd2, {24'h0, code});
    endtask

    task automatic store_wr(input logic [7:0] code, input logic [31:0] a, input logic [31:0] d);
        bus_wr(2'd0, d);
        bus_wr(2'd1, a);
        issue(code);
        idle(2);
    endtask

    task automatic store_rd(input logic [7:0] code, input logic [31:0] a, output logic [31:0] d);
        logic r;
        bus_wr(2'd1, a);
        issue(code);
        idle(3);
        bus_rd(2'd0, d, r);
    endtask

    task automatic status(output logic [31:0] s);
        logic r;
        bus_rd(2'd2, s, r);
    endtask

    task automatic t_reset;
        logic [31:0] s;
        chk("R1 ready", 32'(bus_ready), 32'h0);
        chk("R1 watch", 32'(watch_count), 32'h0);
        chk("R1 prof", prof_count, 32'h0);
        chk("R1 running", 32'(running), 32'h0);
        status(s);
        chk("R1 status", s, S_HALT | S_CLEAN);
    endtask

    task automatic t_regmap;
        logic [31:0] d;
        logic r;
        bus_wr(2'd1, 32'h0000_005A);
        bus_rd(2'd1, d, r);
        chk("R2 addr word", d, 32'h0000_005A);
        chk("R2 ready with read", 32'(r), 32'h1);
        idle(1);
        chk("R2 ready drops", 32'(bus_ready), 32'h0);
        bus_wr(2'd0, 32'hCAFE_0001);
        bus_rd(2'd0, d, r);
        chk("R2 data word", d, 32'hCAFE_0001);
        bus_wr(2'd3, 32'hFFFF_FFFF);
        bus_rd(2'd3, d, r);
        chk("R2 offset 3 reads 0", d, 32'h0);
        bus_rd(2'd0, d, r);
        chk("R2 offset 3 write ignored", d, 32'hCAFE_0001);
    endtask

    task automatic t_imem;
        logic [31:0] d;
        store_wr(8'h11, 32'd3, 32'h1234_5678);
        store_wr(8'h11, 32'd200, 32'hA5A5_0F0F);
        store_rd(8'h10, 32'd3, d);
        chk("R3 imem[3]", d, 32'h1234_5678);
        store_rd(8'h10, 32'd200, d);
        chk("R3 imem[200]", d, 32'hA5A5_0F0F);
    endtask

    task automatic t_dmem;
        logic [31:0] d;
        store_wr(8'h13, 32'd3, 32'h0BAD_F00D);
        store_rd(8'h12, 32'd3, d);
        chk("R4 dmem[3]", d, 32'h0BAD_F00D);
        store_rd(8'h10, 32'd3, d);
        chk("R4 imem[3] untouched", d, 32'h1234_5678);
    endtask

    task automatic t_ctx;
        logic [31:0] d;
        store_wr(8'h15, 32'd4, 32'hFFFF_FFFF);
        store_wr(8'h15, 32'd5, 32'h1234_5678);
        store_rd(8'h14, 32'd4, d);
        chk("R5 level-0 mask", d, 32'h9FFF_0700);
        store_rd(8'h14, 32'd5, d);
        chk("R5 full word", d, 32'h1234_5678);
    endtask

    task automatic t_latency;
        logic [31:0] d;
        logic r;
        store_wr(8'h11, 32'd7, 32'h1111_2222);
        bus_wr(2'd0, 32'hDEAD_BEEF);
        bus_wr(2'd1, 32'd7);
        issue(8'h10);
        bus_rd(2'd0, d, r);
        chk("R6 early read stale", d, 32'hDEAD_BEEF);
        idle(1);
        bus_rd(2'd0, d, r);
        chk("R6 late read fresh", d, 32'h1111_2222);
    endtask

    task automatic t_step_flush;
        logic [31:0] s;
        logic [WCW-1:0] w;
        w = watch_count;
        issue(8'h01);
        idle(1);
        chk("R10 step +1", 32'(watch_count), 32'(w) + 32'd1);
        issue(8'h01);
        idle(1);
        chk("R10 second step", 32'(watch_count), 32'(w) + 32'd2);
        issue(8'h04);
        idle(2);
        status(s);
        chk("R9 flush flags", s, S_HALT | S_FLUSH | S_CLEAN);
        issue(8'h01);
        idle(2);
        status(s);
        chk("R9 step clears flush", s, S_HALT);
    endtask

    task automatic t_run_stop;
        logic [31:0] s;
        logic [31:0] p;
        logic [WCW-1:0] w;
        issue(8'h04);
        idle(2);
        issue(8'h02);
        idle(2);
        status(s);
        chk("R7 start status", s, S_RUN);
        chk("R7 running port", 32'(running), 32'h1);
        idle(5);
        chk("R12 counts while running", 32'(prof_count > 0), 32'h1);
        w = watch_count;
        issue(8'h01);
        idle(3);
        chk("R11 step ignored", 32'(watch_count), 32'(w));
        issue(8'h03);
        idle(2);
        status(s);
        chk("R8 stop status", s, S_HALT);
        p = prof_count;
        idle(5);
        chk("R12 holds when stopped", prof_count, p);
        issue(8'h0C);
        idle(2);
        chk("R12 cleared", prof_count, 32'h0);
    endtask

    task automatic t_unknown;
        logic [31:0] s0, s1, d;
        logic [WCW-1:0] w;
        logic r;
        status(s0);
        w = watch_count;
        bus_wr(2'd0, 32'h7777_7777);
        bus_wr(2'd1, 32'd3);
        issue(8'h55);
        issue(8'h00);
        issue(8'h16);
        idle(3);
        status(s1);
        chk("R13 status unchanged", s1, s0);
        chk("R13 watch unchanged", 32'(watch_count), 32'(w));
        chk("R13 prof unchanged", prof_count, 32'h0);
        bus_rd(2'd0, d, r);
        chk("R13 data word unchanged", d, 32'h7777_7777);
        store_rd(8'h10, 32'd3, d);
        chk("R13 imem unchanged", d, 32'h1234_5678);
        store_rd(8'h12, 32'd3, d);
        chk("R13 dmem unchanged", d, 32'h0BAD_F00D);
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset;
        t_regmap;
        t_imem;
        t_dmem;
        t_ctx;
        t_latency;
        t_step_flush;
        t_run_stop;
        t_unknown;
        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule